// File: doc/BRIEF.md
# Windowed RGB565 Display Command Receiver

This block is the front end of a small colour panel controller. It takes a four-wire serial link (serial clock, serial data, an active-low select and a line that marks each byte as either an opcode or data) and samples it with its own system clock. The bytes are decoded as single-byte opcodes, each followed by its parameter bytes. The block holds a rectangular write window, a pixel pointer that walks that window in raster order, an orientation and colour-order register, an interface lock and a panel enable flag.

After a memory-write opcode, each pair of data bytes forms one 16-bit RGB565 pixel. The pixel goes into an on-chip frame store at the pointer's position, and the pointer then advances. A host sets the window, issues the write opcode and streams pixels, so a partial screen update costs only the bytes of the changed rectangle. A combinational readback port exposes any frame-store location. The frame store is COLS by ROWS pixels, and both must be powers of two. The full-size panel uses 128 by 128, while the default parameters build a 32 by 32 store so that the block elaborates quickly. Coordinate parameters use their low log2(COLS) or log2(ROWS) bits.

Top module: `rgb565_cmd_rx`

## Requirements
- R1: A byte is shifted in MSB first, one bit on each rising serial clock while the select is low. The opcode/data line is captured with the eighth bit (low = opcode, high = data). A high select clears any partly received byte.
- R2: After reset the panel is off, the remap register reads 0x00, the interface is locked and the restricted-access flag is clear.
- R3: While the interface is locked, every opcode other than 0xFD is ignored, and so are its data bytes.
- R4: Opcode 0xFD followed by 0x12 unlocks the interface. When the interface is already unlocked, 0xFD followed by 0xB1 sets the restricted-access flag. Any other parameter value changes nothing.
- R5: Opcode 0xAE turns the panel flag off and opcode 0xAF turns it on.
- R6: Opcode 0xA0 loads its single parameter byte into the remap register.
- R7: Opcode 0x15 takes a start column and then an end column. Opcode 0x75 takes a start row and then an end row. Both bounds are inclusive.
- R8: Opcode 0x5C places the pointer at the window's start column and start row. Each following pair of data bytes is one pixel, high byte first, stored at the pointer.
- R9: After each stored pixel the pointer moves to the next column. Past the end column it returns to the start column on the next row. Past the end row it returns to the window origin.
- R10: When remap bit 1 is set, a pixel at logical column c is stored at column COLS-1-c.
- R11: When remap bit 2 is set, the 5-bit red field (bits 15:11) and the 5-bit blue field (bits 4:0) are exchanged before the pixel is stored.
- R12: Any opcode byte ends a memory write, so later data bytes store nothing.
- R13: A rising select discards a pixel whose high byte has arrived but whose low byte has not.
- R14: An unrecognised opcode is ignored, together with all of its data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, sampled |
| ser_data | input | 1 | Serial data, MSB first |
| ser_cs_n | input | 1 | Active-low link select |
| ser_dc | input | 1 | Byte kind: 0 opcode, 1 data |
| rd_col | input | log2(COLS) | Readback column (physical) |
| rd_row | input | log2(ROWS) | Readback row |
| rd_pixel | output | 16 | Frame-store content at readback address |
| panel_on | output | 1 | Panel enable flag |
| remap_cfg | output | 8 | Remap / colour-depth register |
| if_unlocked | output | 1 | Interface unlocked |
| restricted_ok | output | 1 | Restricted-access flag |

## Verification
The assertions check on every cycle that state changes only after the right kind of byte. A frame-store write always follows a data byte. The panel flag moves only after an opcode. The remap register moves only after a data byte. Unlocking follows only the 0x12 key, and the panel flag holds while the interface is locked. Only the bench's scenarios can show the pointer's raster path and wrap, column mirroring, colour swap, the discard of half a pixel on deselect, and byte re-framing after a select pulse, because each of these is visible only as frame-store content read back through the port.

// File: rtl/rgbcmd_pkg.sv
package rgbcmd_pkg;

    localparam logic [7:0] OPC_COLWIN = 8'h15;
    localparam logic [7:0] OPC_ROWWIN = 8'h75;
    localparam logic [7:0] OPC_MEMWR  = 8'h5C;
    localparam logic [7:0] OPC_REMAP  = 8'hA0;
    localparam logic [7:0] OPC_LOCK   = 8'hFD;
    localparam logic [7:0] OPC_OFF    = 8'hAE;
    localparam logic [7:0] OPC_ON     = 8'hAF;

    localparam logic [7:0] KEY_UNLOCK   = 8'h12;
    localparam logic [7:0] KEY_RESTRICT = 8'hB1;

    localparam int REMAP_COLREV = 1;
    localparam int REMAP_BGR    = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_COL,
        OP_ROW,
        OP_WRITE,
        OP_REMAP,
        OP_LOCK
    } op_e;

    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] cnt;
        logic       sclk_prev;
        logic       cs_prev;
        logic       vld;
        logic [7:0] byte_o;
        logic       isdat;
        logic       cs_rise;
    } rx_state_t;

endpackage

// File: rtl/rgbcmd_sync.sv
module rgbcmd_sync #(
    parameter int W        = 4,
    parameter int STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
        end else begin
            st_q[0] <= din;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/rgbcmd_serial_rx.sv
module rgbcmd_serial_rx
    import rgbcmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_cs_n,
    input  logic       ser_dc,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       byte_is_data,
    output logic       cs_rise
);
    logic [3:0] raw_s;
    logic       sclk_s, sd_s, cs_s, dc_s;

    rgbcmd_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_clk, ser_cs_n, ser_data, ser_dc}),
        .dout (raw_s)
    );
    assign sclk_s = raw_s[3];
    assign cs_s   = raw_s[2];
    assign sd_s   = raw_s[1];
    assign dc_s   = raw_s[0];

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d           = rx_q;
        rx_d.vld       = 1'b0;
        rx_d.cs_rise   = 1'b0;
        rx_d.sclk_prev = sclk_s;
        rx_d.cs_prev   = cs_s;
        if (cs_s) begin
            rx_d.cnt = '0;
            if (!rx_q.cs_prev) rx_d.cs_rise = 1'b1;
        end else if (sclk_s && !rx_q.sclk_prev) begin
            rx_d.sh  = {rx_q.sh[6:0], sd_s};
            rx_d.cnt = rx_q.cnt + 3'd1;
            if (rx_q.cnt == 3'd7) begin
                rx_d.vld    = 1'b1;
                rx_d.byte_o = {rx_q.sh[6:0], sd_s};
                rx_d.isdat  = dc_s;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q         <= '0;
            rx_q.cs_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld     = rx_q.vld;
    assign byte_data    = rx_q.byte_o;
    assign byte_is_data = rx_q.isdat;
    assign cs_rise      = rx_q.cs_rise;
endmodule

// File: rtl/rgbcmd_decoder.sv
module rgbcmd_decoder
    import rgbcmd_pkg::*;
#(
    parameter int COLS = 32,
    parameter int ROWS = 32,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_data,
    input  logic          byte_is_data,
    input  logic          cs_rise,
    output logic          panel_on,
    output logic [7:0]    remap_cfg,
    output logic          if_unlocked,
    output logic          restricted_ok,
    output logic          wr_en,
    output logic [CW-1:0] wr_col,
    output logic [RW-1:0] wr_row,
    output logic [15:0]   wr_data
);
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

    typedef struct packed {
        op_e           op;
        logic [1:0]    pidx;
        logic [CW-1:0] col_s;
        logic [CW-1:0] col_e;
        logic [RW-1:0] row_s;
        logic [RW-1:0] row_e;
        logic [CW-1:0] col_p;
        logic [RW-1:0] row_p;
        logic          half;
        logic [7:0]    hi;
        logic [7:0]    remap;
        logic          disp;
        logic          unl;
        logic          ext;
        logic          wr_en;
        logic [CW-1:0] wr_col;
        logic [RW-1:0] wr_row;
        logic [15:0]   wr_data;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic [15:0] pix_raw;

    assign pix_raw = {st_q.hi, byte_data};

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (cs_rise) st_d.half = 1'b0;
        if (byte_vld) begin
            if (!byte_is_data) begin
                st_d.half = 1'b0;
                st_d.pidx = '0;
                st_d.op   = OP_NONE;
                if (st_q.unl || byte_data == OPC_LOCK) begin
                    case (byte_data)
                        OPC_COLWIN: st_d.op = OP_COL;
                        OPC_ROWWIN: st_d.op = OP_ROW;
                        OPC_REMAP:  st_d.op = OP_REMAP;
                        OPC_LOCK:   st_d.op = OP_LOCK;
                        OPC_OFF:    st_d.disp = 1'b0;
                        OPC_ON:     st_d.disp = 1'b1;
                        OPC_MEMWR: begin
                            st_d.op    = OP_WRITE;
                            st_d.col_p = st_q.col_s;
                            st_d.row_p = st_q.row_s;
                        end
                        default: st_d.op = OP_NONE;
                    endcase
                end
            end else begin
                case (st_q.op)
                    OP_COL: begin
                        if (st_q.pidx == 2'd0) st_d.col_s = byte_data[CW-1:0];
                        if (st_q.pidx == 2'd1) st_d.col_e = byte_data[CW-1:0];
                        if (st_q.pidx != 2'd2) st_d.pidx  = st_q.pidx + 2'd1;
                    end
                    OP_ROW: begin
                        if (st_q.pidx == 2'd0) st_d.row_s = byte_data[RW-1:0];
                        if (st_q.pidx == 2'd1) st_d.row_e = byte_data[RW-1:0];
                        if (st_q.pidx != 2'd2) st_d.pidx  = st_q.pidx + 2'd1;
                    end
                    OP_REMAP: begin
                        if (st_q.pidx == 2'd0) st_d.remap = byte_data;
                        st_d.pidx = 2'd1;
                    end
                    OP_LOCK: begin
                        if (st_q.pidx == 2'd0) begin
                            if (byte_data == KEY_UNLOCK) st_d.unl = 1'b1;
                            if (byte_data == KEY_RESTRICT && st_q.unl) st_d.ext = 1'b1;
                        end
                        st_d.pidx = 2'd1;
                    end
                    OP_WRITE: begin
                        if (!st_q.half) begin
                            st_d.hi   = byte_data;
                            st_d.half = 1'b1;
                        end else begin
                            st_d.half    = 1'b0;
                            st_d.wr_en   = 1'b1;
                            st_d.wr_row  = st_q.row_p;
                            st_d.wr_col  = st_q.remap[REMAP_COLREV] ? (COL_MAX - st_q.col_p)
                                                                    : st_q.col_p;
                            st_d.wr_data = st_q.remap[REMAP_BGR]
                                         ? {pix_raw[4:0], pix_raw[10:5], pix_raw[15:11]}
                                         : pix_raw;
                            if (st_q.col_p == st_q.col_e) begin
                                st_d.col_p = st_q.col_s;
                                st_d.row_p = (st_q.row_p == st_q.row_e) ? st_q.row_s
                                                                        : st_q.row_p + RW'(1);
                            end else begin
                                st_d.col_p = st_q.col_p + CW'(1);
                            end
                        end
                    end
                    default: st_d.op = OP_NONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign panel_on      = st_q.disp;
    assign remap_cfg     = st_q.remap;
    assign if_unlocked   = st_q.unl;
    assign restricted_ok = st_q.ext;
    assign wr_en         = st_q.wr_en;
    assign wr_col        = st_q.wr_col;
    assign wr_row        = st_q.wr_row;
    assign wr_data       = st_q.wr_data;
endmodule

// File: rtl/rgbcmd_frame.sv
module rgbcmd_frame #(
    parameter int COLS = 32,
    parameter int ROWS = 32,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int DEPTH = COLS * ROWS
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_col,
    input  logic [RW-1:0] wr_row,
    input  logic [15:0]   wr_data,
    input  logic [CW-1:0] rd_col,
    input  logic [RW-1:0] rd_row,
    output logic [15:0]   rd_pixel
);
    logic [15:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_row, wr_col}] <= wr_data;
    end

    assign rd_pixel = mem_q[{rd_row, rd_col}];
endmodule

// File: rtl/rgb565_cmd_rx.sv
module rgb565_cmd_rx #(
    parameter int COLS        = 32,
    parameter int ROWS        = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_data,
    input  logic          ser_cs_n,
    input  logic          ser_dc,
    input  logic [CW-1:0] rd_col,
    input  logic [RW-1:0] rd_row,
    output logic [15:0]   rd_pixel,
    output logic          panel_on,
    output logic [7:0]    remap_cfg,
    output logic          if_unlocked,
    output logic          restricted_ok
);
    logic          byte_vld;
    logic [7:0]    byte_data;
    logic          byte_is_data;
    logic          cs_rise;
    logic          wr_en;
    logic [CW-1:0] wr_col;
    logic [RW-1:0] wr_row;
    logic [15:0]   wr_data;

    rgbcmd_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_cs_n    (ser_cs_n),
        .ser_dc      (ser_dc),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .byte_is_data(byte_is_data),
        .cs_rise     (cs_rise)
    );

    rgbcmd_decoder #(.COLS(COLS), .ROWS(ROWS)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .byte_is_data (byte_is_data),
        .cs_rise      (cs_rise),
        .panel_on     (panel_on),
        .remap_cfg    (remap_cfg),
        .if_unlocked  (if_unlocked),
        .restricted_ok(restricted_ok),
        .wr_en        (wr_en),
        .wr_col       (wr_col),
        .wr_row       (wr_row),
        .wr_data      (wr_data)
    );

    rgbcmd_frame #(.COLS(COLS), .ROWS(ROWS)) u_frame (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_col  (wr_col),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_col  (rd_col),
        .rd_row  (rd_row),
        .rd_pixel(rd_pixel)
    );
endmodule

// File: rtl/rgb565_cmd_rx_chk.sv
module rgb565_cmd_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       byte_is_data,
    input logic       wr_en,
    input logic       panel_on,
    input logic [7:0] remap_cfg,
    input logic       if_unlocked
);
    p_wr_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_vld && byte_is_data));

    p_panel_by_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(panel_on) |-> $past(byte_vld && !byte_is_data));

    p_remap_by_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remap_cfg) |-> $past(byte_vld && byte_is_data));

    p_unlock_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_unlocked) |-> $past(byte_vld && byte_is_data && byte_data == 8'h12));

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!if_unlocked) && $past(byte_vld && !byte_is_data && byte_data != 8'hFD))
        |-> $stable(panel_on));
endmodule

bind rgb565_cmd_rx rgb565_cmd_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .byte_is_data(byte_is_data),
    .wr_en       (wr_en),
    .panel_on    (panel_on),
    .remap_cfg   (remap_cfg),
    .if_unlocked (if_unlocked)
);

// File: tb/rgb565_cmd_rx_bench.sv
module rgb565_cmd_rx_bench;
    localparam int COLS = 32;
    localparam int ROWS = 32;
    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);

    // {column, row, expected pixel} after eight writes into a 3x2 window
    localparam logic [31:0] EXP_TAB [6] = '{
        {8'd2, 8'd1, 16'hA006},
        {8'd3, 8'd1, 16'hA007},
        {8'd4, 8'd1, 16'hA002},
        {8'd2, 8'd2, 16'hA003},
        {8'd3, 8'd2, 16'hA004},
        {8'd4, 8'd2, 16'hA005}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_cs_n = 1'b1, ser_dc = 1'b0;
    logic [CW-1:0] rd_col = '0;
    logic [RW-1:0] rd_row = '0;
    logic [15:0] rd_pixel;
    logic panel_on, if_unlocked, restricted_ok;
    logic [7:0] remap_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rgb565_cmd_rx #(.COLS(COLS), .ROWS(ROWS)) u_rgb565_cmd_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_cs_n(ser_cs_n), .ser_dc(ser_dc), .rd_col(rd_col), .rd_row(rd_row),
        .rd_pixel(rd_pixel), .panel_on(panel_on), .remap_cfg(remap_cfg),
        .if_unlocked(if_unlocked), .restricted_ok(restricted_ok)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_byte(input logic isd, input logic [7:0] b);
        ser_dc = isd;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        send_byte(1'b0, b);
    endtask

    task automatic dat(input logic [7:0] b);
        send_byte(1'b1, b);
    endtask

    task automatic pixel(input logic [15:0] p);
        dat(p[15:8]);
        dat(p[7:0]);
    endtask

    task automatic window(input logic [7:0] c0, input logic [7:0] c1,
                          input logic [7:0] r0, input logic [7:0] r1);
        cmd(8'h15); dat(c0); dat(c1);
        cmd(8'h75); dat(r0); dat(r1);
    endtask

    task automatic rd_check(input string tag, input int c, input int r, input logic [15:0] exp);
        rd_col = CW'(c);
        rd_row = RW'(r);
        #1;
        check(tag, rd_pixel, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 reset state
        check("R2 panel_on", {15'd0, panel_on}, 16'd0);
        check("R2 remap", {8'd0, remap_cfg}, 16'h0000);
        check("R2 unlocked", {15'd0, if_unlocked}, 16'd0);
        check("R2 restricted", {15'd0, restricted_ok}, 16'd0);

        ser_cs_n = 1'b0;
        repeat (4) @(negedge clk);

        // R3 locked: opcodes other than 0xFD ignored
        cmd(8'hAF);
        check("R3 panel stays off while locked", {15'd0, panel_on}, 16'd0);
        cmd(8'hA0); dat(8'h46);
        check("R3 remap ignored while locked", {8'd0, remap_cfg}, 16'h0000);
        // R4 restricted key before unlock, then a wrong key, then unlock
        cmd(8'hFD); dat(8'hB1);
        check("R4 restricted needs unlock", {15'd0, restricted_ok}, 16'd0);
        cmd(8'hFD); dat(8'h34);
        check("R4 wrong key", {15'd0, if_unlocked}, 16'd0);
        cmd(8'hFD); dat(8'h12);
        check("R4 unlock", {15'd0, if_unlocked}, 16'd1);
        cmd(8'hFD); dat(8'hB1);
        check("R4 restricted set", {15'd0, restricted_ok}, 16'd1);

        // R5 panel on/off
        cmd(8'hAF);
        check("R5 on", {15'd0, panel_on}, 16'd1);
        cmd(8'hAE);
        check("R5 off", {15'd0, panel_on}, 16'd0);
        cmd(8'hAF);
        check("R5 on again", {15'd0, panel_on}, 16'd1);

        // R6 remap load
        cmd(8'hA0); dat(8'h40);
        check("R6 remap", {8'd0, remap_cfg}, 16'h0040);

        // R7 R8 R9 window write with raster wrap, table driven
        window(8'd2, 8'd4, 8'd1, 8'd2);
        cmd(8'h5C);
        for (int i = 0; i < 8; i++) pixel(16'hA000 + 16'(i));
        for (int k = 0; k < 6; k++)
            rd_check("R9 window raster", int'(EXP_TAB[k][31:24]), int'(EXP_TAB[k][23:16]),
                     EXP_TAB[k][15:0]);

        // R12 opcode ends the write; pointer would be at (4,1)
        cmd(8'hAF);
        dat(8'h55); dat(8'h66);
        rd_check("R12 write ended", 4, 1, 16'hA002);

        // R14 unknown opcode with data ignored
        cmd(8'h99);
        dat(8'h77); dat(8'h88); dat(8'h01);
        rd_check("R14 unknown opcode mem", 4, 1, 16'hA002);
        check("R14 unknown opcode remap", {8'd0, remap_cfg}, 16'h0040);
        check("R14 unknown opcode panel", {15'd0, panel_on}, 16'd1);

        // R10 column reversal
        cmd(8'hA0); dat(8'h42);
        window(8'd0, 8'd1, 8'd5, 8'd5);
        cmd(8'h5C);
        pixel(16'h1234);
        pixel(16'h5678);
        rd_check("R10 mirrored col 0", COLS - 1, 5, 16'h1234);
        rd_check("R10 mirrored col 1", COLS - 2, 5, 16'h5678);

        // R11 red/blue exchange
        cmd(8'hA0); dat(8'h44);
        window(8'd0, 8'd0, 8'd0, 8'd0);
        cmd(8'h5C);
        pixel(16'hF803);
        rd_check("R11 bgr swap", 0, 0, 16'h181F);

        // R13 deselect drops half a pixel
        cmd(8'hA0); dat(8'h40);
        window(8'd6, 8'd6, 8'd6, 8'd6);
        cmd(8'h5C);
        dat(8'hAB);
        ser_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        ser_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        pixel(16'h1234);
        rd_check("R13 half pixel discarded", 6, 6, 16'h1234);

        // R1 deselect re-frames a partial byte
        ser_dc = 1'b0;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        ser_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        ser_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        cmd(8'hAE);
        check("R1 byte framing after deselect", {15'd0, panel_on}, 16'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule